// File: doc/BRIEF.md
# Link Port Quad-Word Receiver

This block is the receive half of a point-to-point link. A transmitter sends a link clock, a data lane and a block-completion flag. The receiver takes one data sample on every transition of that link clock, on rising and on falling edges alike. It gathers the samples into a 128-bit shift register that software cannot reach. Once a whole quad-word has arrived, it moves the word into a two-stage receive buffer. A core or a DMA channel reads that buffer through a read strobe.

The lane width is set in a control register: either four data lines, which take 32 samples per word, or one data line, which takes 128 samples per word. The acknowledge output tells the transmitter whether another word can be accepted. The block-completion input can flag the word that closes a block. The link clock is oversampled in the system clock domain: it is registered, and any change of level counts as a sample edge.

The control register also stores a verification enable and a timeout enable. These bits can be read back but have no effect on the datapath.

Top module: `lp_rx`

## Requirements
- R1: After reset, `ack_out` is 0, `ctl_rdata` is 0, `stat_rdata` is 0 and `buf_rdata` is 0.
- R2: A `ctl_wr` strobe stores `ctl_wdata[5:0]` in the control register. The fields are: bit 0 receive enable, bit 1 verification enable, bit 2 timeout enable, bit 3 block-completion enable, bits 5:4 lane width. Bits 31:6 of `ctl_rdata` always read 0.
- R3: While the receiver is enabled, each change of `lclk_in`, rising or falling, takes exactly one sample. A word is not complete one sample before its final sample.
- R4: With width code 2'b01 (4-bit lane), a word is 32 samples of `ldat_in[3:0]`. Sample k lands in bits 4k+3:4k, so the first sample is least significant.
- R5: With any other width code (1-bit lane), a word is 128 samples of `ldat_in[0]`. Sample k lands in bit k.
- R6: After the final sample of a word, status bit 0 (data valid) is 1 and `buf_rdata` shows the oldest unread word.
- R7: The buffer holds two words in arrival order. Status bit 2 is 1 when both stages are full. A `buf_rd` strobe frees the oldest stage, and the next word then appears on `buf_rdata`.
- R8: `ack_out` is 1 exactly when the receiver is enabled and fewer than two buffer stages are full.
- R9: A word that completes while both stages are full, with no read in the same cycle, is discarded, and the buffered words are unchanged.
- R10: Status bit 1 (block done) is set when block-completion enable is 1 and `bcmp_in` was high at any sample of a completed word. Any control write clears it. With the enable at 0, the bit is never set.
- R11: Clearing the receive enable resets the sample count and discards a partial word. Link clock edges seen while the receiver is disabled are ignored.
- R12: A `buf_rd` strobe while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lclk_in | input | 1 | Link clock from the transmitter |
| ldat_in | input | 4 | Link data lane |
| bcmp_in | input | 1 | Block-completion flag from the transmitter |
| ack_out | output | 1 | Ready-for-data acknowledge to the transmitter |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register read value |
| stat_rdata | output | 32 | Status: bit 0 valid, bit 1 block done, bit 2 full |
| buf_rd | input | 1 | Receive buffer read strobe |
| buf_rdata | output | 128 | Oldest unread quad-word |

## Verification
On every cycle, the assertions check these properties:
- The buffer occupancy never exceeds two stages.
- A dropped word leaves the stored words untouched.
- A read promotes the second stage in order.
- A disabled receiver holds a zero sample count.
- The acknowledge falls when the buffer is full.
- Block done can only rise while its enable is set.

Only the bench scenarios can show the following:
- Bit placement within an assembled word in both lane widths.
- Taking one sample per link clock edge.
- Discarding a partial word across a disable.
- The end-to-end data order through the buffer.

// File: rtl/lp_rx_pkg.sv
package lp_rx_pkg;
  localparam int LANE_W = 4;
  localparam int WORD_W = 128;
  localparam int CNT_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    WID_1B  = 2'b00,
    WID_4B  = 2'b01,
    WID_1BA = 2'b10,
    WID_1BB = 2'b11
  } width_e;

  typedef struct packed {
    logic [1:0] width;
    logic       bcmp_en;
    logic       tmo_en;
    logic       ver_en;
    logic       en;
  } rx_ctl_t;

  function automatic logic is_wide(logic [1:0] w);
    return w == WID_4B;
  endfunction

  function automatic logic [CNT_W-1:0] last_index(logic wide);
    return wide ? CNT_W'(WORD_W / LANE_W - 1) : CNT_W'(WORD_W - 1);
  endfunction

  function automatic logic [WORD_W-1:0] shift_in(logic [WORD_W-1:0] sr,
                                                 logic [LANE_W-1:0] smp,
                                                 logic wide);
    return wide ? {smp, sr[WORD_W-1:LANE_W]} : {smp[0], sr[WORD_W-1:1]};
  endfunction
endpackage

// File: rtl/lp_rx_edge.sv
module lp_rx_edge
  import lp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lclk,
  input  logic [LANE_W-1:0] ldat,
  input  logic              bcmp,
  output logic              strobe,
  output logic [LANE_W-1:0] smp_data,
  output logic              smp_bcmp
);
  logic lclk_d1, lclk_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lclk_d1  <= 1'b0;
      lclk_d2  <= 1'b0;
      smp_data <= '0;
      smp_bcmp <= 1'b0;
    end else begin
      lclk_d1  <= lclk;
      lclk_d2  <= lclk_d1;
      smp_data <= ldat;
      smp_bcmp <= bcmp;
    end
  end

  // any level change of the link clock is a sample point
  assign strobe = lclk_d1 ^ lclk_d2;
endmodule

// File: rtl/lp_rx_assembler.sv
module lp_rx_assembler
  import lp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wide,
  input  logic              strobe,
  input  logic [LANE_W-1:0] smp,
  input  logic              bc,
  output logic              word_done,
  output logic [WORD_W-1:0] word,
  output logic              word_bcmp
);
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              bc_seen;
  logic              at_last;

  always_comb begin
    word      = shift_in(sr, smp, wide);
    at_last   = cnt >= last_index(wide);
    word_done = en && strobe && at_last;
    word_bcmp = bc_seen | bc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      bc_seen <= 1'b0;
    end else if (!en) begin
      sr      <= '0;
      cnt     <= '0;
      bc_seen <= 1'b0;
    end else if (strobe) begin
      sr <= word;
      if (at_last) begin
        cnt     <= '0;
        bc_seen <= 1'b0;
      end else begin
        cnt     <= cnt + 1'b1;
        bc_seen <= bc_seen | bc;
      end
    end
  end

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0); // R11
  AST_DONE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> cnt == '0); // R3
endmodule

// File: rtl/lp_rx_buffer.sv
module lp_rx_buffer
  import lp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              rd,
  output logic [WORD_W-1:0] front,
  output logic [1:0]        fill,
  output logic              accept
);
  logic [WORD_W-1:0] back;
  logic              rd_eff;

  always_comb begin
    rd_eff = rd && (fill != 2'd0);
    accept = push && ((fill != 2'd2) || rd_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front <= '0;
      back  <= '0;
      fill  <= 2'd0;
    end else begin
      case ({rd_eff, accept})
        2'b11: begin
          if (fill == 2'd1) front <= push_word;
          else begin
            front <= back;
            back  <= push_word;
          end
        end
        2'b10: begin
          front <= back;
          fill  <= fill - 2'd1;
        end
        2'b01: begin
          if (fill == 2'd0) front <= push_word;
          else back <= push_word;
          fill <= fill + 2'd1;
        end
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 2'd2); // R7
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fill == 2'd2 && !rd) |=> (fill == 2'd2 && $stable(front) && $stable(back))); // R9
  AST_FIFO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && fill == 2'd2 && !push) |=> front == $past(back)); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && fill == 2'd0 && !push) |=> fill == 2'd0); // R12
endmodule

// File: rtl/lp_rx.sv
module lp_rx
  import lp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lclk_in,
  input  logic [LANE_W-1:0] ldat_in,
  input  logic              bcmp_in,
  output logic              ack_out,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  output logic [31:0]       stat_rdata,
  input  logic              buf_rd,
  output logic [WORD_W-1:0] buf_rdata
);
  localparam int CTL_W = $bits(rx_ctl_t);

  rx_ctl_t           ctl;
  logic              block_done;
  logic              strobe, smp_bcmp;
  logic [LANE_W-1:0] smp_data;
  logic              word_done, word_bcmp, accept;
  logic [WORD_W-1:0] word;
  logic [1:0]        fill;
  logic              unused_rsvd;

  assign unused_rsvd = ^ctl_wdata[31:CTL_W] ^ accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl        <= '0;
      block_done <= 1'b0;
    end else begin
      if (ctl_wr) ctl <= rx_ctl_t'(ctl_wdata[CTL_W-1:0]);
      if (ctl_wr) block_done <= 1'b0;
      else if (word_done && word_bcmp && ctl.bcmp_en) block_done <= 1'b1;
    end
  end

  lp_rx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lclk(lclk_in), .ldat(ldat_in), .bcmp(bcmp_in),
    .strobe(strobe), .smp_data(smp_data), .smp_bcmp(smp_bcmp)
  );

  lp_rx_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .wide(is_wide(ctl.width)),
    .strobe(strobe), .smp(smp_data), .bc(smp_bcmp),
    .word_done(word_done), .word(word), .word_bcmp(word_bcmp)
  );

  lp_rx_buffer u_buf (
    .clk(clk), .rst_n(rst_n), .push(word_done), .push_word(word), .rd(buf_rd),
    .front(buf_rdata), .fill(fill), .accept(accept)
  );

  always_comb begin
    ack_out    = ctl.en && (fill != 2'd2);
    ctl_rdata  = {{(32-CTL_W){1'b0}}, ctl};
    stat_rdata = {29'd0, fill == 2'd2, block_done, fill != 2'd0};
  end

  AST_ACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == 2'd2 && !buf_rd) |=> !ack_out); // R8
  AST_DONE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_done) |-> $past(ctl.bcmp_en)); // R10
endmodule

// File: tb/lp_rx_tb.sv
module lp_rx_tb;
  logic         clk = 0, rst_n = 0;
  logic         lclk_in = 0, bcmp_in = 0, ctl_wr = 0, buf_rd = 0;
  logic [3:0]   ldat_in = 0;
  logic [31:0]  ctl_wdata = 0;
  logic         ack_out;
  logic [31:0]  ctl_rdata, stat_rdata;
  logic [127:0] buf_rdata;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lp_rx u_dut (.*);

  // entry: {wide, word}
  localparam logic [128:0] VEC [4] = '{
    {1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},
    {1'b0, 128'h8000_0000_0000_0000_0000_0000_0000_0001},
    {1'b1, 128'hFFFF_0000_A5A5_5A5A_DEAD_BEEF_0F0F_F0F0},
    {1'b0, 128'h1357_9BDF_2468_ACE0_C001_D00D_7777_1111}
  };

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [31:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic rd_buf();
    @(negedge clk); buf_rd = 1;
    @(negedge clk); buf_rd = 0;
  endtask

  task automatic send(logic [127:0] w, bit wide, bit bc, int from, int to);
    for (int k = from; k <= to; k++) begin
      @(negedge clk);
      ldat_in = wide ? w[4*k +: 4] : {3'b0, w[k]};
      bcmp_in = bc;
      lclk_in = ~lclk_in;
      @(negedge clk);
    end
    bcmp_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(logic [127:0] w, bit wide, bit bc);
    send(w, wide, bc, 0, wide ? 31 : 127);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] wa, wb, wc;
    wa = 128'hAAAA_1111_2222_3333_4444_5555_6666_7777;
    wb = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    wc = 128'hCAFE_F00D_0000_FFFF_1234_5678_9ABC_DEF0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ack", ack_out, 0);
    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 stat", stat_rdata, 0);
    chk("R1 buf", buf_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 reserved bits read zero, R8 ack low while disabled
    wr_ctl(32'hFFFF_FFFE);
    chk("R2 ctl readback", ctl_rdata, 32'h3E);
    chk("R8 ack disabled", ack_out, 0);

    // table walk: R4 / R5 / R6
    for (int i = 0; i < 4; i++) begin
      wr_ctl(VEC[i][128] ? 32'h11 : 32'h01);
      chk("R8 ack enabled", ack_out, 1);
      send_word(VEC[i][127:0], VEC[i][128], 0);
      chk("R6 valid", stat_rdata[0], 1);
      chk(VEC[i][128] ? "R4 4-bit word" : "R5 1-bit word", buf_rdata, VEC[i][127:0]);
      rd_buf();
      chk("R7 read frees", stat_rdata, 0);
    end

    // R3 one sample per edge: 31 samples do not complete a word
    wr_ctl(32'h11);
    send(wa, 1, 0, 0, 30);
    chk("R3 incomplete", stat_rdata[0], 0);
    send(wa, 1, 0, 31, 31);
    chk("R3 complete", stat_rdata[0], 1);
    chk("R3 data", buf_rdata, wa);
    rd_buf();

    // R7 / R8 / R9 two stages, overflow drop
    send_word(wa, 1, 0);
    chk("R8 ack one full", ack_out, 1);
    send_word(wb, 1, 0);
    chk("R7 full flag", stat_rdata[2], 1);
    chk("R8 ack full", ack_out, 0);
    send_word(wc, 1, 0);
    chk("R9 head kept", buf_rdata, wa);
    rd_buf();
    chk("R7 order", buf_rdata, wb);
    chk("R8 ack after read", ack_out, 1);
    rd_buf();
    chk("R9 dropped word absent", stat_rdata, 0);

    // R10 block completion
    wr_ctl(32'h19);
    send(wb, 1, 0, 0, 4);
    send(wb, 1, 1, 5, 5);
    send(wb, 1, 0, 6, 31);
    chk("R10 block done", stat_rdata[1], 1);
    rd_buf();
    wr_ctl(32'h19);
    chk("R10 cleared by write", stat_rdata[1], 0);
    wr_ctl(32'h11);
    send_word(wc, 1, 1);
    chk("R10 disabled stays low", stat_rdata[1], 0);
    rd_buf();

    // R11 disable discards partial word and ignores edges
    send(wa, 1, 0, 0, 9);
    wr_ctl(32'h10);
    send(wb, 1, 0, 0, 2);
    chk("R11 no word while disabled", stat_rdata[0], 0);
    wr_ctl(32'h11);
    send_word(wc, 1, 0);
    chk("R11 clean restart", buf_rdata, wc);
    rd_buf();

    // R12 empty read
    rd_buf();
    chk("R12 empty read", stat_rdata, 0);
    wr_ctl(32'h01);
    send_word(wb, 0, 0);
    chk("R12 next word intact", buf_rdata, wb);
    chk("R12 single stage", stat_rdata[2:0], 3'b001);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule